// File: doc/BRIEF.md
# RGB Panel Video Timing Generator

This block produces the raster timing for a parallel RGB display: horizontal sync, vertical sync, a data-enable strobe marking the visible area, a divided pixel clock with a matching one-cycle pixel enable, and the current pixel and line position. Every interval (sync width, back porch, active size, front porch, in both directions) is programmed as its length minus one. Each of the four panel-facing strobes can be inverted on its own. A frame interrupt pulse fires at a programmable line of the vertical period.

The block runs from one source clock. A divider, programmed as ratio minus one, sets how many source cycles make up one pixel. Timing fields, divider and interrupt point pass through a frame-boundary shadow, so software may rewrite them at any time without tearing the current frame. While the enable input is low the shadow follows the inputs directly, the counters sit at zero and every strobe rests at its inactive level.

Top module: `rgb_timing_gen`

## Requirements
- R1: While `en` is low, `hsync`, `vsync`, `de` and `pclk` equal their inversion bits (inactive level), `pclk_en` and `frame_irq` are 0, and `px` and `py` are 0.
- R2: A line is made of `hsw_m1+1` sync pixels, then `hbp_m1+1` back-porch pixels, then `hact_m1+1` active pixels, then `hfp_m1+1` front-porch pixels; `px` gives the pixel index from 0 at the start of the sync; `hsync` (before inversion) is 1 during the sync pixels only.
- R3: A frame is made of `vsw_m1+1` sync lines, `vbp_m1+1` back-porch lines, `vact_m1+1` active lines and `vfp_m1+1` front-porch lines in that order; `py` gives the line index from 0; `vsync` (before inversion) is 1 during the sync lines only.
- R4: `de` (before inversion) is 1 exactly when the pixel lies in the horizontal active span and the line lies in the vertical active span; it is never active during horizontal sync.
- R5: Each of `hsync`, `vsync`, `de` and `pclk` is its active-high value XOR its own inversion bit (`inv_hs`, `inv_vs`, `inv_de`, `inv_pclk`).
- R6: With ratio N = `div_m1+1`, each pixel lasts N source cycles; `pclk_en` is 1 in the last of them; `pclk` (before inversion) is 1 for the first ceil(N/2) of them; `px` and `py` change only after a cycle with `pclk_en` high.
- R7: A divider field of 255 is treated as a ratio of 255 (divider values 0 to 254 give ratios 1 to 255).
- R8: `frame_irq` is a one-cycle pulse in the first source cycle of pixel 0 of a selected line: `irq_sel`=0 line 0 (start of vertical sync), 1 first back-porch line, 2 first active line, 3 first front-porch line.
- R9: Timing fields, divider and `irq_sel` written while enabled take effect at the start of the next frame; the frame in progress completes with the old values.
- R10: When `en` rises, the first source cycle shows pixel 0 of line 0 with both syncs active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Video enable |
| hsw_m1 | input | TW | Horizontal sync width minus one |
| hbp_m1 | input | TW | Horizontal back porch minus one |
| hfp_m1 | input | TW | Horizontal front porch minus one |
| vsw_m1 | input | TW | Vertical sync width minus one |
| vbp_m1 | input | TW | Vertical back porch minus one |
| vfp_m1 | input | TW | Vertical front porch minus one |
| hact_m1 | input | AW | Active width minus one |
| vact_m1 | input | AW | Active height minus one |
| div_m1 | input | 8 | Pixel clock ratio minus one |
| inv_hs | input | 1 | Invert horizontal sync |
| inv_vs | input | 1 | Invert vertical sync |
| inv_de | input | 1 | Invert data enable |
| inv_pclk | input | 1 | Invert pixel clock |
| irq_sel | input | 2 | Frame interrupt line select |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pclk | output | 1 | Pixel clock |
| pclk_en | output | 1 | One-cycle pixel advance strobe |
| frame_irq | output | 1 | Frame interrupt pulse |
| px | output | AW+2 | Pixel index within the line |
| py | output | AW+2 | Line index within the frame |

## Verification
The bench goes after minimum-length intervals (every field 0 with a ratio of 1), where an off-by-one in the minus-one decoding shifts or merges whole regions and the expected strobes go out of step at once. A divider field of 255 is run through a full frame: a design that wrapped the ratio to 256, or to 0, puts `pclk_en` at the wrong cycle. Timing fields are rewritten in mid-frame; a design without the frame shadow changes line lengths in the frame in progress, and one that loads late keeps the old geometry for one frame too many. Random polarity and interrupt selections catch a strobe inverted with the wrong bit or an interrupt tied to the wrong boundary line.

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen #(
  parameter int TW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] hsw_m1,
  input  logic [TW-1:0] hbp_m1,
  input  logic [TW-1:0] hfp_m1,
  input  logic [TW-1:0] vsw_m1,
  input  logic [TW-1:0] vbp_m1,
  input  logic [TW-1:0] vfp_m1,
  input  logic [AW-1:0] hact_m1,
  input  logic [AW-1:0] vact_m1,
  input  logic [7:0]    div_m1,
  input  logic          inv_hs,
  input  logic          inv_vs,
  input  logic          inv_de,
  input  logic          inv_pclk,
  input  logic [1:0]    irq_sel,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pclk,
  output logic          pclk_en,
  output logic          frame_irq,
  output logic [AW+1:0] px,
  output logic [AW+1:0] py
);
  localparam int CW = AW + 2;

  logic [CW-1:0] hb_n, ha_n, hf_n, ht_n, vb_n, va_n, vf_n, vt_n;
  logic [CW-1:0] hb_q, ha_q, hf_q, ht_q, vb_q, va_q, vf_q, vt_q;
  logic [7:0]    div_n, div_q, dcnt;
  logic [1:0]    sel_q;
  logic [CW-1:0] hc, vc, irq_line;
  logic [8:0]    half;
  logic          tick, last, load;

  assign hb_n = CW'(hsw_m1) + CW'(1);
  assign ha_n = hb_n + CW'(hbp_m1) + CW'(1);
  assign hf_n = ha_n + CW'(hact_m1) + CW'(1);
  assign ht_n = hf_n + CW'(hfp_m1);
  assign vb_n = CW'(vsw_m1) + CW'(1);
  assign va_n = vb_n + CW'(vbp_m1) + CW'(1);
  assign vf_n = va_n + CW'(vact_m1) + CW'(1);
  assign vt_n = vf_n + CW'(vfp_m1);
  assign div_n = (div_m1 == 8'hFF) ? 8'hFE : div_m1;

  assign tick = (dcnt == div_q);
  assign last = tick && (hc == ht_q) && (vc == vt_q);
  assign load = !en || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {hb_q, ha_q, hf_q, ht_q} <= '0;
      {vb_q, va_q, vf_q, vt_q} <= '0;
      div_q <= '0;
      sel_q <= '0;
      dcnt  <= '0;
      hc    <= '0;
      vc    <= '0;
    end else begin
      if (load) begin
        {hb_q, ha_q, hf_q, ht_q} <= {hb_n, ha_n, hf_n, ht_n};
        {vb_q, va_q, vf_q, vt_q} <= {vb_n, va_n, vf_n, vt_n};
        div_q <= div_n;
        sel_q <= irq_sel;
      end
      if (!en) begin
        dcnt <= '0;
        hc   <= '0;
        vc   <= '0;
      end else begin
        dcnt <= tick ? 8'd0 : dcnt + 8'd1;
        if (tick) begin
          if (hc == ht_q) begin
            hc <= '0;
            vc <= (vc == vt_q) ? '0 : vc + CW'(1);
          end else begin
            hc <= hc + CW'(1);
          end
        end
      end
    end
  end

  always_comb begin
    case (sel_q)
      2'd0:    irq_line = '0;
      2'd1:    irq_line = vb_q;
      2'd2:    irq_line = va_q;
      default: irq_line = vf_q;
    endcase
  end

  assign half = ({1'b0, div_q} + 9'd2) >> 1;

  assign hsync     = (en && (hc < hb_q)) ^ inv_hs;
  assign vsync     = (en && (vc < vb_q)) ^ inv_vs;
  assign de        = (en && (hc >= ha_q) && (hc < hf_q) && (vc >= va_q) && (vc < vf_q)) ^ inv_de;
  assign pclk      = (en && ({1'b0, dcnt} < half)) ^ inv_pclk;
  assign pclk_en   = en && tick;
  assign frame_irq = en && (dcnt == 8'd0) && (hc == '0) && (vc == irq_line);
  assign px        = en ? hc : '0;
  assign py        = en ? vc : '0;
endmodule

// File: rtl/rgb_timing_gen_chk.sv
module rgb_timing_gen_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          inv_hs,
  input logic          inv_vs,
  input logic          inv_de,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          pclk_en,
  input logic          frame_irq,
  input logic [AW+1:0] px,
  input logic [AW+1:0] py
);
  a_r10_start_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (px == '0) && (py == '0) && (hsync ^ inv_hs) && (vsync ^ inv_vs));

  a_r4_de_not_in_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    (de ^ inv_de) |-> !(hsync ^ inv_hs));

  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);

  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pclk_en) |=> (!en || ($stable(px) && $stable(py))));
endmodule

bind rgb_timing_gen rgb_timing_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_rgb_timing_gen.sv
`timescale 1ns/1ps
module tb_rgb_timing_gen;
  localparam int TW = 8;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [TW-1:0] hsw_m1 = '0, hbp_m1 = '0, hfp_m1 = '0;
  logic [TW-1:0] vsw_m1 = '0, vbp_m1 = '0, vfp_m1 = '0;
  logic [AW-1:0] hact_m1 = '0, vact_m1 = '0;
  logic [7:0] div_m1 = '0;
  logic inv_hs = 0, inv_vs = 0, inv_de = 0, inv_pclk = 0;
  logic [1:0] irq_sel = '0;
  logic hsync, vsync, de, pclk, pclk_en, frame_irq;
  logic [AW+1:0] px, py;

  always #2.5 clk = ~clk;

  rgb_timing_gen #(.TW(TW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .hsw_m1(hsw_m1), .hbp_m1(hbp_m1), .hfp_m1(hfp_m1),
    .vsw_m1(vsw_m1), .vbp_m1(vbp_m1), .vfp_m1(vfp_m1),
    .hact_m1(hact_m1), .vact_m1(vact_m1), .div_m1(div_m1),
    .inv_hs(inv_hs), .inv_vs(inv_vs), .inv_de(inv_de), .inv_pclk(inv_pclk),
    .irq_sel(irq_sel),
    .hsync(hsync), .vsync(vsync), .de(de), .pclk(pclk), .pclk_en(pclk_en),
    .frame_irq(frame_irq), .px(px), .py(py)
  );

  int checks = 0, fails = 0;
  int m_hsw, m_hbp, m_hact, m_hfp, m_vsw, m_vbp, m_vact, m_vfp, m_r, m_sel;
  int tf;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (frame cycle %0d)", tag, act, exp, tf);
    end
  endtask

  task automatic grab();
    m_hsw = int'(hsw_m1) + 1; m_hbp = int'(hbp_m1) + 1;
    m_hact = int'(hact_m1) + 1; m_hfp = int'(hfp_m1) + 1;
    m_vsw = int'(vsw_m1) + 1; m_vbp = int'(vbp_m1) + 1;
    m_vact = int'(vact_m1) + 1; m_vfp = int'(vfp_m1) + 1;
    m_r = (div_m1 == 8'hFF) ? 255 : int'(div_m1) + 1;
    m_sel = int'(irq_sel);
  endtask

  function automatic int frame_len();
    return (m_hsw + m_hbp + m_hact + m_hfp) * (m_vsw + m_vbp + m_vact + m_vfp) * m_r;
  endfunction

  task automatic check_cycle();
    int htot, p, sub, hc, vc, eh, ev, ed, irql;
    htot = m_hsw + m_hbp + m_hact + m_hfp;
    p = tf / m_r;
    sub = tf % m_r;
    hc = p % htot;
    vc = p / htot;
    eh = (hc < m_hsw) ? 1 : 0;
    ev = (vc < m_vsw) ? 1 : 0;
    ed = (hc >= m_hsw + m_hbp && hc < m_hsw + m_hbp + m_hact &&
          vc >= m_vsw + m_vbp && vc < m_vsw + m_vbp + m_vact) ? 1 : 0;
    case (m_sel)
      0: irql = 0;
      1: irql = m_vsw;
      2: irql = m_vsw + m_vbp;
      default: irql = m_vsw + m_vbp + m_vact;
    endcase
    chk("R2/R5 hsync", int'(hsync), eh ^ int'(inv_hs));
    chk("R2 px", int'(px), hc);
    chk("R3/R5 vsync", int'(vsync), ev ^ int'(inv_vs));
    chk("R3 py", int'(py), vc);
    chk("R4/R5 de", int'(de), ed ^ int'(inv_de));
    chk("R6/R5 pclk", int'(pclk), ((sub < (m_r + 1) / 2) ? 1 : 0) ^ int'(inv_pclk));
    chk("R6 pclk_en", int'(pclk_en), (sub == m_r - 1) ? 1 : 0);
    chk("R8 frame_irq", int'(frame_irq), (sub == 0 && hc == 0 && vc == irql) ? 1 : 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      check_cycle();
      @(negedge clk); #1;
      tf++;
      if (tf == frame_len()) begin
        tf = 0;
        grab();
      end
    end
  endtask

  task automatic start();
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    #1;
    tf = 0;
    grab();
    chk("R10 px at enable", int'(px), 0);
    chk("R10 py at enable", int'(py), 0);
    chk("R10 hsync active at enable", int'(hsync ^ inv_hs), 1);
    chk("R10 vsync active at enable", int'(vsync ^ inv_vs), 1);
  endtask

  task automatic idle_check();
    en = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 hsync idle", int'(hsync), int'(inv_hs));
    chk("R1 vsync idle", int'(vsync), int'(inv_vs));
    chk("R1 de idle", int'(de), int'(inv_de));
    chk("R1 pclk idle", int'(pclk), int'(inv_pclk));
    chk("R1 pclk_en idle", int'(pclk_en), 0);
    chk("R1 frame_irq idle", int'(frame_irq), 0);
    chk("R1 px idle", int'(px), 0);
    chk("R1 py idle", int'(py), 0);
  endtask

  task automatic rand_cfg(input bit keep_inv);
    hsw_m1 = TW'($urandom_range(0, 3)); hbp_m1 = TW'($urandom_range(0, 3));
    hfp_m1 = TW'($urandom_range(0, 3)); hact_m1 = AW'($urandom_range(0, 7));
    vsw_m1 = TW'($urandom_range(0, 3)); vbp_m1 = TW'($urandom_range(0, 3));
    vfp_m1 = TW'($urandom_range(0, 3)); vact_m1 = AW'($urandom_range(0, 7));
    div_m1 = 8'($urandom_range(0, 3));
    irq_sel = 2'($urandom_range(0, 3));
    if (!keep_inv) begin
      inv_hs = 1'($urandom_range(0, 1)); inv_vs = 1'($urandom_range(0, 1));
      inv_de = 1'($urandom_range(0, 1)); inv_pclk = 1'($urandom_range(0, 1));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int fx;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state with all polarities normal, then all inverted
    idle_check();
    {inv_hs, inv_vs, inv_de, inv_pclk} = 4'hF;
    idle_check();

    // R2 R3 R10: minimum intervals, ratio 1, interrupt at front porch (R8)
    {inv_hs, inv_vs, inv_de, inv_pclk} = 4'h0;
    {hsw_m1, hbp_m1, hfp_m1, vsw_m1, vbp_m1, vfp_m1} = '0;
    hact_m1 = '0; vact_m1 = '0; div_m1 = 8'd0; irq_sel = 2'd3;
    start();
    run(2 * frame_len() + 3);
    idle_check();

    // R7: divider field 255 gives ratio 255
    div_m1 = 8'hFF; irq_sel = 2'd2; inv_pclk = 1'b1;
    start();
    run(frame_len() + 300);
    idle_check();

    // Random geometries, polarities, ratios and interrupt points
    for (int k = 0; k < 8; k++) begin
      rand_cfg(1'b0);
      start();
      run(2 * frame_len() + 5);
      idle_check();
    end

    // R9: rewrite timing in mid-frame; old values finish the frame
    rand_cfg(1'b0);
    start();
    fx = frame_len();
    run(37);
    rand_cfg(1'b1);
    hact_m1 = AW'(9);
    div_m1 = 8'd2;
    run(fx - 37 + frame_len() + 20);
    idle_check();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule